// File: doc/BRIEF.md
# Multichannel Audio Sample FIFO

This block buffers interleaved audio samples for one direction of a serial audio port. One side pushes 24-bit sample words and the other side pops them in the same order. For the output direction the CPU pushes and the serial shifter pops. For the input direction the roles swap. Samples are grouped into frames of one word per channel, and the block counts and reports only complete frames.

The storage holds `256 << SIZE_CODE` words. The number of frames it accepts is that word depth divided by the channel count rounded up to a power of two, so three channels take the space of four. A status word carries the frame fill level, a sticky overrun flag and a sticky underrun flag. A control write can empty the FIFO and can enable a half-level service request. The request polarity depends on the direction.

Top module: `mch_sample_fifo`

## Requirements
- R1: The word depth is 256 shifted left by SIZE_CODE. The frame capacity is the word depth divided by the smallest power of two that is at least `chan_cnt` (1 to 8). A value of 0 is treated as 1 and a value above 8 is treated as 8.
- R2: `stat_rdata[16:8]` holds the number of stored frames. A frame is counted once its last word (word number `chan_cnt`) is pushed. It stops being counted once its last word is popped.
- R3: A push while the level equals the capacity is dropped and sets the overrun flag `stat_rdata[4]`. The level and the stored data stay unchanged.
- R4: A pop while the level is 0 makes `pop_data` zero and sets the underrun flag `stat_rdata[0]`.
- R5: Both flags are sticky. A status write with `stat_wovr`/`stat_wudr` low clears the matching flag, and with the input high it keeps the flag. An event in the same cycle as a clearing write leaves the flag set.
- R6: A control write with `ctrl_clr` high empties the FIFO and discards any partial frame. The flags are not changed, and a push or pop in that cycle is ignored.
- R7: `ctrl_half`, latched on every control write, enables `half_req`. With OUT_DIR=1, `half_req` is high while level <= capacity/2. With OUT_DIR=0 it is high while level >= capacity/2. It is low while disabled.
- R8: Words come out in push order, one word per pop, on `pop_data` in the cycle after the pop. All 24 bits are kept, so a 16-bit sample placed in bits [23:8] returns unchanged.
- R9: After reset the level, both flags, the half enable and `pop_data` are zero.
- R10: A push and a pop in the same cycle are both performed. Fullness and emptiness are judged on the state before that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chan_cnt | input | 4 | Channels per frame, 1 to 8 |
| ctrl_we | input | 1 | Control write strobe |
| ctrl_clr | input | 1 | Control write: empty the FIFO (bit 0 of the control word) |
| ctrl_half | input | 1 | Control write: half-level request enable (bit 20 of the control word) |
| stat_we | input | 1 | Status write strobe |
| stat_wovr | input | 1 | Status write value for the overrun bit (0 clears) |
| stat_wudr | input | 1 | Status write value for the underrun bit (0 clears) |
| stat_rdata | output | 32 | Status: [16:8] frame level, [4] overrun, [0] underrun |
| push | input | 1 | Store one word |
| push_data | input | 24 | Word to store |
| pop | input | 1 | Remove one word |
| pop_data | output | 24 | Word popped, valid the cycle after `pop` |
| half_req | output | 1 | Half-level service request |

## Verification
Some behaviours are checked by the in-RTL assertions on every cycle:
- the frame level moves by at most one per cycle;
- a push into a full FIFO leaves the level unchanged and raises overrun;
- a pop from an empty FIFO gives zero and raises underrun;
- the flags stay set until a clearing write;
- a clear empties the level;
- disabling the request drops it.

Other behaviours need the bench's scenarios:
- frame capacity for every channel count from 1 to 8;
- counting of partial frames;
- data order and integrity over a full fill and drain;
- the half-level threshold for both directions;
- simultaneous push and pop.

// File: rtl/mch_sample_fifo_pkg.sv
package mch_sample_fifo_pkg;
  localparam int BASE_LOG2   = 8;
  localparam int SAMPLE_W    = 24;
  localparam int STAT_W      = 32;
  localparam int ST_LVL_LSB  = 8;
  localparam int ST_LVL_W    = 9;
  localparam int ST_OVR_BIT  = 4;
  localparam int ST_UDR_BIT  = 0;
  localparam int CHAN_W      = 4;
  localparam int SUB_W       = 3;

  // log2 of the power-of-two slot group a frame occupies
  function automatic logic [1:0] group_shift(input logic [CHAN_W-1:0] ch);
    logic [1:0] s;
    if (ch <= 4'd1)      s = 2'd0;
    else if (ch == 4'd2) s = 2'd1;
    else if (ch <= 4'd4) s = 2'd2;
    else                 s = 2'd3;
    return s;
  endfunction
endpackage

// File: rtl/mch_sample_fifo_geom.sv
module mch_sample_fifo_geom
  import mch_sample_fifo_pkg::*;
#(
  parameter int AW    = 8,
  parameter int LVL_W = AW + 1
) (
  input  logic [CHAN_W-1:0] chan_cnt,
  output logic [LVL_W-1:0]  cap,
  output logic [LVL_W-1:0]  half,
  output logic [SUB_W-1:0]  last_idx
);
  localparam logic [LVL_W-1:0] DEPTH_L = LVL_W'(1) << AW;

  logic [CHAN_W-1:0] chan_eff;

  always_comb begin
    if (chan_cnt == '0)             chan_eff = 4'd1;
    else if (chan_cnt > 4'd8)       chan_eff = 4'd8;
    else                            chan_eff = chan_cnt;
    last_idx = SUB_W'(chan_eff - 4'd1);
    // R1: frame capacity from slot group size
    cap  = DEPTH_L >> group_shift(chan_eff);
    half = cap >> 1;
  end
endmodule

// File: rtl/mch_sample_fifo_track.sv
module mch_sample_fifo_track
  import mch_sample_fifo_pkg::*;
#(
  parameter int AW    = 8,
  parameter int LVL_W = AW + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             push_ok,
  input  logic             pop_ok,
  input  logic [SUB_W-1:0] last_idx,
  output logic [AW-1:0]    wr_ptr,
  output logic [AW-1:0]    rd_ptr,
  output logic [LVL_W-1:0] level
);
  logic [SUB_W-1:0] wr_sub, rd_sub, wr_sub_n, rd_sub_n;
  logic [AW-1:0]    wr_ptr_n, rd_ptr_n;
  logic [LVL_W-1:0] level_n;
  logic             wr_done, rd_done, upd;

  always_comb begin
    wr_done  = push_ok && (wr_sub == last_idx);
    rd_done  = pop_ok  && (rd_sub == last_idx);
    upd      = clr || push_ok || pop_ok;
    wr_sub_n = wr_sub;
    rd_sub_n = rd_sub;
    wr_ptr_n = wr_ptr;
    rd_ptr_n = rd_ptr;
    level_n  = level;
    if (clr) begin
      wr_sub_n = '0;
      rd_sub_n = '0;
      wr_ptr_n = '0;
      rd_ptr_n = '0;
      level_n  = '0;
    end else begin
      if (push_ok) begin
        wr_ptr_n = wr_ptr + 1'b1;
        wr_sub_n = wr_done ? '0 : wr_sub + 1'b1;
      end
      if (pop_ok) begin
        rd_ptr_n = rd_ptr + 1'b1;
        rd_sub_n = rd_done ? '0 : rd_sub + 1'b1;
      end
      level_n = level + LVL_W'(wr_done) - LVL_W'(rd_done);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_sub <= '0;
      rd_sub <= '0;
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else if (upd) begin
      wr_sub <= wr_sub_n;
      rd_sub <= rd_sub_n;
      wr_ptr <= wr_ptr_n;
      rd_ptr <= rd_ptr_n;
      level  <= level_n;
    end
  end

  // R2: the frame level never jumps by more than one frame outside a clear
  a_r2_level_step: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (level == $past(level)) || (level == $past(level) + 1'b1) ||
             (level == $past(level) - 1'b1));
endmodule

// File: rtl/mch_sample_fifo_store.sv
module mch_sample_fifo_store
  import mch_sample_fifo_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = SAMPLE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  input  logic          rd_hit,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] rd_data_n;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  always_comb rd_data_n = rd_hit ? mem[rd_addr] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_en) rd_data <= rd_data_n;
  end
endmodule

// File: rtl/mch_sample_fifo.sv
module mch_sample_fifo
  import mch_sample_fifo_pkg::*;
#(
  parameter int SIZE_CODE = 0,
  parameter bit OUT_DIR   = 1'b1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [CHAN_W-1:0]   chan_cnt,
  input  logic                ctrl_we,
  input  logic                ctrl_clr,
  input  logic                ctrl_half,
  input  logic                stat_we,
  input  logic                stat_wovr,
  input  logic                stat_wudr,
  output logic [STAT_W-1:0]   stat_rdata,
  input  logic                push,
  input  logic [SAMPLE_W-1:0] push_data,
  input  logic                pop,
  output logic [SAMPLE_W-1:0] pop_data,
  output logic                half_req
);
  localparam int AW    = BASE_LOG2 + SIZE_CODE;
  localparam int LVL_W = AW + 1;

  logic [LVL_W-1:0] cap, half, level;
  logic [SUB_W-1:0] last_idx;
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic             clr, full, empty, push_ok, pop_ok, push_drop, pop_miss;
  logic             half_en, ovr, udr, half_en_n, ovr_n, udr_n, flag_upd;
  logic             lvl_cond;

  mch_sample_fifo_geom #(.AW(AW), .LVL_W(LVL_W)) u_geom (
    .chan_cnt (chan_cnt),
    .cap      (cap),
    .half     (half),
    .last_idx (last_idx)
  );

  always_comb begin
    clr       = ctrl_we && ctrl_clr;
    full      = (level == cap);
    empty     = (level == '0);
    push_ok   = push && !clr && !full;
    pop_ok    = pop  && !clr && !empty;
    push_drop = push && !clr && full;
    pop_miss  = pop  && !clr && empty;
  end

  mch_sample_fifo_track #(.AW(AW), .LVL_W(LVL_W)) u_track (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr),
    .push_ok  (push_ok),
    .pop_ok   (pop_ok),
    .last_idx (last_idx),
    .wr_ptr   (wr_ptr),
    .rd_ptr   (rd_ptr),
    .level    (level)
  );

  mch_sample_fifo_store #(.AW(AW), .DW(SAMPLE_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (push_ok),
    .wr_addr (wr_ptr),
    .wr_data (push_data),
    .rd_en   (pop && !clr),
    .rd_hit  (pop_ok),
    .rd_addr (rd_ptr),
    .rd_data (pop_data)
  );

  // sticky flags and request enable
  always_comb begin
    half_en_n = ctrl_we ? ctrl_half : half_en;
    ovr_n     = ovr;
    udr_n     = udr;
    if (stat_we && !stat_wovr) ovr_n = 1'b0;
    if (stat_we && !stat_wudr) udr_n = 1'b0;
    if (push_drop)             ovr_n = 1'b1;
    if (pop_miss)              udr_n = 1'b1;
    flag_upd  = ctrl_we || stat_we || push_drop || pop_miss;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_en <= 1'b0;
      ovr     <= 1'b0;
      udr     <= 1'b0;
    end else if (flag_upd) begin
      half_en <= half_en_n;
      ovr     <= ovr_n;
      udr     <= udr_n;
    end
  end

  generate
    if (OUT_DIR) begin : g_out
      assign lvl_cond = (level <= half);
    end else begin : g_in
      assign lvl_cond = (level >= half);
    end
  endgenerate

  assign half_req = half_en && lvl_cond;

  always_comb begin
    stat_rdata = '0;
    stat_rdata[ST_LVL_LSB +: ST_LVL_W] = ST_LVL_W'(level);
    stat_rdata[ST_OVR_BIT] = ovr;
    stat_rdata[ST_UDR_BIT] = udr;
  end

  a_r3_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
    push && !pop && !ctrl_we && (stat_rdata[16:8] == ST_LVL_W'(cap))
    |=> (stat_rdata[16:8] == $past(stat_rdata[16:8])) && stat_rdata[4]);

  a_r4_empty_zero: assert property (@(posedge clk) disable iff (!rst_n)
    pop && !ctrl_we && (stat_rdata[16:8] == '0) |=> (pop_data == '0) && stat_rdata[0]);

  a_r5_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rdata[4] && !stat_we |=> stat_rdata[4]);

  a_r5_udr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rdata[0] && !stat_we |=> stat_rdata[0]);

  a_r6_clear_empty: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_we && ctrl_clr |=> (stat_rdata[16:8] == '0));

  a_r7_req_off: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_we && !ctrl_half |=> !half_req);
endmodule

// File: tb/mch_sample_fifo_bench.sv
module mch_sample_fifo_bench;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  chan_cnt;
  logic        ctrl_we, ctrl_clr, ctrl_half;
  logic        stat_we, stat_wovr, stat_wudr;
  logic [31:0] stat_rdata, stat_rdata_in;
  logic        push, pop;
  logic [23:0] push_data, pop_data, pop_data_in;
  logic        half_req, half_req_in;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  mch_sample_fifo #(.SIZE_CODE(0), .OUT_DIR(1'b1)) u_mch_sample_fifo (
    .clk(clk), .rst_n(rst_n), .chan_cnt(chan_cnt),
    .ctrl_we(ctrl_we), .ctrl_clr(ctrl_clr), .ctrl_half(ctrl_half),
    .stat_we(stat_we), .stat_wovr(stat_wovr), .stat_wudr(stat_wudr),
    .stat_rdata(stat_rdata), .push(push), .push_data(push_data),
    .pop(pop), .pop_data(pop_data), .half_req(half_req));

  mch_sample_fifo #(.SIZE_CODE(0), .OUT_DIR(1'b0)) u_mch_sample_fifo_in (
    .clk(clk), .rst_n(rst_n), .chan_cnt(chan_cnt),
    .ctrl_we(ctrl_we), .ctrl_clr(ctrl_clr), .ctrl_half(ctrl_half),
    .stat_we(stat_we), .stat_wovr(stat_wovr), .stat_wudr(stat_wudr),
    .stat_rdata(stat_rdata_in), .push(push), .push_data(push_data),
    .pop(pop), .pop_data(pop_data_in), .half_req(half_req_in));

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #(CLK_P/4);
  endtask

  task automatic do_push(input logic [23:0] d);
    push = 1'b1; push_data = d; step(); push = 1'b0;
  endtask

  task automatic do_pop();
    pop = 1'b1; step(); pop = 1'b0;
  endtask

  task automatic wr_ctrl(input bit c, input bit h);
    ctrl_we = 1'b1; ctrl_clr = c; ctrl_half = h; step();
    ctrl_we = 1'b0; ctrl_clr = 1'b0;
  endtask

  task automatic wr_stat(input bit o, input bit u);
    stat_we = 1'b1; stat_wovr = o; stat_wudr = u; step(); stat_we = 1'b0;
  endtask

  function automatic logic [23:0] word_of(input int ch, input int i);
    return 24'((ch << 16) | (i & 16'hFFFF));
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %h expected %h", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; chan_cnt = 4'd1;
    ctrl_we = 0; ctrl_clr = 0; ctrl_half = 0;
    stat_we = 0; stat_wovr = 0; stat_wudr = 0;
    push = 0; pop = 0; push_data = '0;
    repeat (3) step();
    rst_n = 1'b1;
    step();
    chk(stat_rdata == 32'h0, "R9", "reset status", stat_rdata, 32'h0);
    chk(pop_data == 24'h0, "R9", "reset pop_data", 32'(pop_data), 32'h0);
    chk(!half_req && !half_req_in, "R9", "reset half_req", 32'({half_req, half_req_in}), 0);

    // full sweep of channel counts
    for (int ch = 1; ch <= 8; ch++) begin
      int cap, hf, gp, lvl;
      gp = 1;
      while (gp < ch) gp = gp * 2;
      cap = 256 / gp;
      hf  = cap / 2;
      chan_cnt = 4'(ch);
      wr_ctrl(1'b1, 1'b1);
      lvl = 0;
      for (int f = 0; f < cap; f++) begin
        for (int w = 0; w < ch; w++) begin
          do_push(word_of(ch, f * ch + w));
          if (f == 0 && w == ch - 2)
            chk(stat_rdata[16:8] == 0, "R2", "partial frame level", 32'(stat_rdata[16:8]), 0);
        end
        lvl = f + 1;
        chk(stat_rdata[16:8] == 9'(lvl), "R2", "level after frame", 32'(stat_rdata[16:8]), lvl);
        chk(half_req == (lvl <= hf), "R7", "out half_req", 32'(half_req), 32'(lvl <= hf));
        chk(half_req_in == (lvl >= hf), "R7", "in half_req", 32'(half_req_in), 32'(lvl >= hf));
      end
      chk(stat_rdata[16:8] == 9'(cap), "R1", "frame capacity", 32'(stat_rdata[16:8]), cap);
      do_push(24'hFFFFFF);
      chk(stat_rdata[4] == 1'b1, "R3", "overrun set", 32'(stat_rdata[4]), 1);
      chk(stat_rdata[16:8] == 9'(cap), "R3", "level after drop", 32'(stat_rdata[16:8]), cap);
      wr_stat(1'b0, 1'b0);
      chk(stat_rdata[4] == 1'b0, "R5", "overrun cleared", 32'(stat_rdata[4]), 0);
      for (int i = 0; i < cap * ch; i++) begin
        do_pop();
        chk(pop_data == word_of(ch, i), "R8", "pop order", 32'(pop_data), 32'(word_of(ch, i)));
        if ((i % ch) == ch - 1)
          chk(stat_rdata[16:8] == 9'(cap - 1 - i / ch), "R2", "level on drain",
              32'(stat_rdata[16:8]), cap - 1 - i / ch);
      end
      do_pop();
      chk(pop_data == 24'h0, "R4", "empty pop data", 32'(pop_data), 0);
      chk(stat_rdata[0] == 1'b1, "R4", "underrun set", 32'(stat_rdata[0]), 1);
      wr_stat(1'b0, 1'b0);
    end

    // sticky keep and clear, clear keeps flags
    chan_cnt = 4'd2;
    wr_ctrl(1'b1, 1'b1);
    do_pop();
    wr_stat(1'b1, 1'b1);
    chk(stat_rdata[0] == 1'b1, "R5", "underrun kept on write 1", 32'(stat_rdata[0]), 1);
    do_push(24'h111111);
    wr_ctrl(1'b1, 1'b1);
    chk(stat_rdata[0] == 1'b1, "R6", "clear keeps flag", 32'(stat_rdata[0]), 1);
    do_push(24'h222222);
    do_push(24'h333333);
    chk(stat_rdata[16:8] == 9'd1, "R6", "partial discarded", 32'(stat_rdata[16:8]), 1);
    do_pop();
    chk(pop_data == 24'h222222, "R6", "data after clear", 32'(pop_data), 32'h222222);
    wr_stat(1'b0, 1'b0);
    chk(stat_rdata[0] == 1'b0, "R5", "underrun cleared", 32'(stat_rdata[0]), 0);

    // simultaneous push and pop
    wr_ctrl(1'b1, 1'b1);
    do_push(24'hA00001);
    do_push(24'hA00002);
    push = 1'b1; pop = 1'b1; push_data = 24'hB00001; step();
    chk(pop_data == 24'hA00001, "R10", "concurrent pop 1", 32'(pop_data), 32'hA00001);
    push_data = 24'hB00002; step();
    push = 1'b0; pop = 1'b0;
    chk(pop_data == 24'hA00002, "R10", "concurrent pop 2", 32'(pop_data), 32'hA00002);
    chk(stat_rdata[16:8] == 9'd1, "R10", "level kept", 32'(stat_rdata[16:8]), 1);
    // 16-bit sample carried in [23:8]
    do_pop();
    chk(pop_data == 24'hB00001, "R8", "concurrent push data", 32'(pop_data), 32'hB00001);
    do_pop();
    wr_ctrl(1'b1, 1'b1);
    do_push(24'hBEEF00);
    do_push(24'h123400);
    do_pop();
    chk(pop_data[23:8] == 16'hBEEF, "R8", "16-bit sample", 32'(pop_data[23:8]), 32'hBEEF);

    // request disabled
    wr_ctrl(1'b1, 1'b0);
    chk(!half_req && !half_req_in, "R7", "request disabled", 32'({half_req, half_req_in}), 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule